// File: doc/BRIEF.md
# Leaky Sampled Digital Integrator

This block integrates a slow stream of 8-bit samples from a bipolar analog-to-digital converter. Each sample comes in offset code, where the code 127 stands for zero. The block converts it to a signed value and adds it into a wide signed accumulator. The accumulator value drives a digital-to-analog converter that is wider than 8 bits. Feeding it a sine input gives a negated cosine at the output, plus a constant offset.

The constant of integration is set by preloading the accumulator. An optional leak lets old data fade, so that a DC offset in the input does not wind the accumulator up. The leak factor is a power of two, picked by a 3-bit control. The accumulator saturates at its limits instead of wrapping. A sticky flag records that saturation has happened.

Top module: `leaky_integrator`

## Requirements
- R1: While reset is held, and after it is released, `acc_out` reads 0 and `ovf` reads 0 until a load or a sample strobe arrives.
- R2: A sample code c is treated as the signed value c − 127. Code 127 adds nothing, code 0 adds −127 and code 255 adds +128.
- R3: With `leak_en` low, each cycle with `smp_vld` high sets the accumulator to x + u, where x is its old value and u is the converted sample.
- R4: With `leak_en` high, a sample strobe sets the accumulator to x − (x >>> n) + u. Here n = `leak_sel` + 1, so n runs from 1 to 8, and >>> is an arithmetic (sign-filling) right shift.
- R5: The accumulator is 20-bit two's complement. A result above 524287 gives 524287, and a result below −524288 gives −524288. It never wraps.
- R6: `ovf` goes high in the cycle that a saturating update becomes visible. It stays high through later samples until a load occurs, and a load clears it.
- R7: When `ld_stb` is high, the accumulator takes `ld_val`, whatever the state of `smp_vld` in the same cycle.
- R8: In a cycle with neither strobe, `acc_out` and `ovf` keep their values, whatever the settings of `leak_en` and `leak_sel`.
- R9: A strobe has its effect on `acc_out` at the first rising clock edge after it is presented. Until that edge, the output shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld | input | 1 | Strobe: the sample on `smp_code` is valid this cycle |
| smp_code | input | 8 | Converter sample in offset code (127 means zero) |
| ld_stb | input | 1 | Strobe: load `ld_val` into the accumulator |
| ld_val | input | 20 | Signed preload value (constant of integration) |
| leak_en | input | 1 | Selects the leaky update for sample strobes |
| leak_sel | input | 3 | Leak shift minus one: the factor is 2^-(leak_sel+1) |
| acc_out | output | 20 | Signed accumulator value |
| ovf | output | 1 | Sticky saturation flag, cleared by a load |

## Verification
Saturation is the hardest case to reach from the ports. Starting from zero, it would take thousands of full-scale samples to get there. The stimulus therefore preloads values a few hundred counts from each limit, then pushes past them with extreme codes. It keeps sampling after the clamp to show that the flag stays set. The leaky path is run with negative preloads and all eight shift settings. This exposes the difference between a sign-filling shift and a logical one, which shows most clearly near −1.

// File: rtl/integ_pkg.sv
package integ_pkg;
  // Default geometry of the integrator
  localparam int SMP_W_D  = 8;
  localparam int ACC_W_D  = 20;
  localparam int ZERO_D   = 127;
  localparam int SEL_W_D  = 3;

  // What the accumulator does in a cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_ACC  = 2'd2
  } acc_act_e;
endpackage

// File: rtl/offset_conv.sv
module offset_conv #(
  parameter int SMP_W = 8,
  parameter int ZERO  = 127
) (
  input  logic [SMP_W-1:0]        code,
  output logic signed [SMP_W:0]   val
);
  localparam logic [SMP_W:0] ZERO_V = (SMP_W+1)'(ZERO);

  logic [SMP_W:0] diff;

  always_comb begin
    diff = {1'b0, code} - ZERO_V;
    val  = $signed(diff);
  end
endmodule

// File: rtl/leak_term.sv
module leak_term #(
  parameter int ACC_W = 20,
  parameter int SEL_W = 3
) (
  input  logic signed [ACC_W-1:0] x,
  input  logic                    en,
  input  logic [SEL_W-1:0]        sel,
  output logic signed [ACC_W-1:0] y
);
  localparam int NSTEP = 1 << SEL_W;

  logic signed [ACC_W-1:0] cand [NSTEP];

  // One decayed candidate per shift amount (shift = index + 1)
  for (genvar i = 0; i < NSTEP; i++) begin : g_shift
    assign cand[i] = x - (x >>> (i + 1));
  end

  always_comb begin
    if (en) y = cand[sel];
    else    y = x;
  end
endmodule

// File: rtl/sat_add.sv
module sat_add #(
  parameter int ACC_W = 20,
  parameter int SMP_W = 8
) (
  input  logic signed [ACC_W-1:0] a,
  input  logic signed [SMP_W:0]   b,
  output logic signed [ACC_W-1:0] y,
  output logic                    hit
);
  localparam int EXT = ACC_W - SMP_W;
  localparam logic signed [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0] wide;

  always_comb begin
    wide = {a[ACC_W-1], a} + {{EXT{b[SMP_W]}}, b};
    hit  = wide[ACC_W] != wide[ACC_W-1];
    if (!hit)             y = wide[ACC_W-1:0];
    else if (wide[ACC_W]) y = NEG_LIM;
    else                  y = POS_LIM;
  end
endmodule

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/leaky_integrator.sv
module leaky_integrator
  import integ_pkg::*;
#(
  parameter int SMP_W = SMP_W_D,
  parameter int ACC_W = ACC_W_D,
  parameter int ZERO  = ZERO_D,
  parameter int SEL_W = SEL_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_code,
  input  logic             ld_stb,
  input  logic [ACC_W-1:0] ld_val,
  input  logic             leak_en,
  input  logic [SEL_W-1:0] leak_sel,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf
);
  logic                    rst_n_i;
  logic signed [SMP_W:0]   u_val;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] decayed, summed;
  logic                    sat_hit;
  logic                    ovf_q, ovf_d;
  logic                    acc_en;
  acc_act_e                act;

  rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  offset_conv #(.SMP_W(SMP_W), .ZERO(ZERO)) u_conv (
    .code (smp_code),
    .val  (u_val)
  );

  leak_term #(.ACC_W(ACC_W), .SEL_W(SEL_W)) u_leak (
    .x   (acc_q),
    .en  (leak_en),
    .sel (leak_sel),
    .y   (decayed)
  );

  sat_add #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_add (
    .a   (decayed),
    .b   (u_val),
    .y   (summed),
    .hit (sat_hit)
  );

  // Action select: load wins over a sample
  always_comb begin
    if (ld_stb)       act = ACT_LOAD;
    else if (smp_vld) act = ACT_ACC;
    else              act = ACT_HOLD;
  end

  // Next-state
  always_comb begin
    acc_d  = acc_q;
    ovf_d  = ovf_q;
    acc_en = 1'b0;
    unique case (act)
      ACT_LOAD: begin
        acc_d  = $signed(ld_val);
        ovf_d  = 1'b0;
        acc_en = 1'b1;
      end
      ACT_ACC: begin
        acc_d  = summed;
        ovf_d  = ovf_q | sat_hit;
        acc_en = 1'b1;
      end
      default: begin
        acc_d  = acc_q;
        ovf_d  = ovf_q;
        acc_en = 1'b0;
      end
    endcase
  end

  // Registers with explicit enable
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_out = acc_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/leaky_integrator_chk.sv
module leaky_integrator_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_vld,
  input logic             ld_stb,
  input logic [ACC_W-1:0] ld_val,
  input logic [ACC_W-1:0] acc_out,
  input logic             ovf
);
  localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ld_stb) |=> (acc_out == $past(ld_val)));

  // R6
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && ld_stb) |=> !ovf);

  // R6
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ld_stb) |=> ovf);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !smp_vld) |=> ($stable(acc_out) && $stable(ovf)));

  // R5
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (acc_out == POS_LIM || acc_out == NEG_LIM));
endmodule

bind leaky_integrator leaky_integrator_chk #(.ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_vld (smp_vld),
  .ld_stb  (ld_stb),
  .ld_val  (ld_val),
  .acc_out (acc_out),
  .ovf     (ovf)
);

// File: tb/sim_leaky_integrator.sv
module sim_leaky_integrator;
  localparam int PERIOD = 10;
  localparam int ACC_W  = 20;
  localparam int MAXV   = 524287;
  localparam int MINV   = -524288;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             smp_vld;
  logic [7:0]       smp_code;
  logic             ld_stb;
  logic [ACC_W-1:0] ld_val;
  logic             leak_en;
  logic [2:0]       leak_sel;
  logic [ACC_W-1:0] acc_out;
  logic             ovf;

  int total = 0;
  int bad   = 0;
  int m_acc = 0;
  bit m_ovf = 1'b0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  leaky_integrator u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_code(smp_code),
    .ld_stb(ld_stb), .ld_val(ld_val), .leak_en(leak_en), .leak_sel(leak_sel),
    .acc_out(acc_out), .ovf(ovf)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int sx(input logic [ACC_W-1:0] v);
    return int'($signed(v));
  endfunction

  // Apply one cycle of stimulus, update the reference, compare after the edge
  task automatic step(input bit vld, input int code, input bit ld, input int val,
                      input bit lk, input int sel, input string req);
    int nxt;
    int old_acc;
    old_acc  = m_acc;
    smp_vld  = vld;
    smp_code = 8'(code);
    ld_stb   = ld;
    ld_val   = ACC_W'(val);
    leak_en  = lk;
    leak_sel = 3'(sel);
    #1;
    // R9: nothing changes before the edge
    check("R9", sx(acc_out), old_acc);
    if (ld) begin
      m_acc = val;
      m_ovf = 1'b0;
    end else if (vld) begin
      nxt = lk ? (m_acc - (m_acc >>> (sel + 1))) : m_acc;
      nxt = nxt + (code - 127);
      if (nxt > MAXV) begin nxt = MAXV; m_ovf = 1'b1; end
      if (nxt < MINV) begin nxt = MINV; m_ovf = 1'b1; end
      m_acc = nxt;
    end
    @(negedge clk);
    check(req, sx(acc_out), m_acc);
    check(req, int'(ovf), int'(m_ovf));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_vld = 0; smp_code = 0; ld_stb = 0; ld_val = '0;
    leak_en = 0; leak_sel = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", sx(acc_out), 0);
    check("R1", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", sx(acc_out), 0);
    check("R1", int'(ovf), 0);

    // R2 conversion corners
    step(1, 127, 0, 0, 0, 0, "R2");
    step(1, 0,   0, 0, 0, 0, "R2");
    step(1, 255, 0, 0, 0, 0, "R2");
    step(1, 128, 0, 0, 0, 0, "R2");
    // R3 plain sum: ramp and triangle wave
    for (int i = 90; i < 170; i += 7) step(1, i, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 0, "R7");
    for (int i = 0; i < 64; i++) begin
      int t;
      t = (i < 16) ? i * 7 : (i < 48) ? (32 - i) * 7 : (i - 64) * 7;
      step(1, 127 + t, 0, 0, 0, 0, "R3");
    end
    // R8 idle with leak selected
    for (int s = 0; s < 8; s++) step(0, 3, 0, 0, 1, s, "R8");

    // R4 leaky with positive and negative preload, every shift
    for (int s = 0; s < 8; s++) begin
      step(0, 0, 1, 10000, 1, s, "R7");
      for (int k = 0; k < 5; k++) step(1, 127 + k * 9, 0, 0, 1, s, "R4");
      step(0, 0, 1, -10001, 1, s, "R7");
      for (int k = 0; k < 5; k++) step(1, 127 - k * 5, 0, 0, 1, s, "R4");
    end
    step(0, 0, 1, -1, 0, 0, "R7");
    step(1, 127, 0, 0, 1, 7, "R4");
    step(1, 127, 0, 0, 1, 0, "R4");

    // R7 load and sample together
    step(1, 255, 1, 4321, 0, 0, "R7");
    step(1, 0, 1, -77, 1, 2, "R7");

    // R5/R6 positive saturation
    step(0, 0, 1, MAXV - 300, 0, 0, "R7");
    for (int k = 0; k < 5; k++) step(1, 255, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 0, "R6");
    step(1, 60, 0, 0, 1, 3, "R6");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 55, 0, 0, "R6");
    // negative saturation
    step(0, 0, 1, MINV + 200, 0, 0, "R7");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, "R5");
    step(1, 200, 0, 0, 0, 0, "R6");
    step(1, 255, 1, 9, 0, 0, "R6");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule